// File: doc/BRIEF.md
# Four-Way Data Memory Resynchronisation Engine

After one tile of a four-tile redundant processor has been rebuilt, its local data memory no longer matches the other three. This engine restores agreement. It sits next to the voter, outside the tiles, and drives one synchronous RAM port into each tile's memory. Every address shares one address bus and one write-data bus. Each tile has its own write enable and its own read-data lane.

The voter issues a start pulse once the rebuild is finished. The engine then steps through every address in ascending order. At each address it reads the four words and looks for a value that at least three tiles hold. It writes that value into every tile whose word differs. Passes repeat until one full pass finds all four memories in agreement at every address, and then a done flag tells the voter it may release the tiles. If an address has no three-way majority, the engine stops at once and raises an unrecoverable flag so that the voter can escalate to full reconfiguration. The same flag is raised if a fixed number of passes each needed repairs. Between recoveries the engine stays idle and leaves the memory ports quiet.

Top module: `mem_resync_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, done and unrecoverable are low, every write enable is low and all four correction counters read zero.
- R2: After start is sampled in the idle state, the engine reads address 0 up to 2^ADDR_W-1 in ascending order. A pass that needs no repair takes two cycles per address (read, compare), so on memories that already agree done rises exactly 2*2^ADDR_W cycles after the start edge.
- R3: At an address where three or four tiles hold the same word, that word is written to each tile that holds a different word, and only that tile's write enable is raised. Tiles that agree are never written.
- R4: An address that needs a repair costs one extra write cycle. Done is raised only at the end of a pass in which no address needed a repair, so a single repairing pass followed by a clean pass ends 4*2^ADDR_W plus the number of repaired addresses cycles after start.
- R5: At an address where no word is held by three or more tiles (a 2-2 split or worse), unrecoverable is raised in the compare cycle, nothing is written at that address, the walk stops and done stays low.
- R6: If MAX_PASSES consecutive passes each needed at least one repair, unrecoverable is raised at the end of the last of those passes instead of starting another pass.
- R7: corr_count holds one saturating counter per tile, with tile t in bits [t*CNT_W +: CNT_W]. A tile's counter increases by one for each word written into that tile, and all counters are cleared when a start is accepted.
- R8: A start pulse that arrives while a walk is in progress is ignored. It neither restarts the walk, nor changes its length, nor clears the counters.
- R9: Done and unrecoverable are never high together. Each holds its value while idle until the next accepted start, which clears both on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a resynchronisation (accepted only when idle) |
| done | output | 1 | All four memories agree; tiles may resume |
| unrecov | output | 1 | Resynchronisation failed; escalate |
| mem_addr | output | ADDR_W | Shared address to all four memories |
| mem_we | output | 4 | Per-tile write enable, bit t for tile t |
| mem_wdata | output | DATA_W | Shared write data (the majority word) |
| mem_rdata | input | 4*DATA_W | Read data, tile t in bits [t*DATA_W +: DATA_W], one-cycle latency |
| corr_count | output | 4*CNT_W | Per-tile count of corrected words |

## Verification
The bound checker checks on every cycle the properties that hold cycle by cycle. With a three-way majority at most one write enable is high, and a write never lasts beyond one cycle. No write happens while unrecoverable is high. The two result flags never overlap and both hold while idle. Each counter changes only after a write to its tile or an accepted start. The bench scenarios cover the rest: which words end up in the memories, the exact number of cycles to done or abort for clean, repairing, split and never-converging memories, a start pulse ignored mid-walk, and counters cleared by a later start. These depend on whole passes and cannot be seen in a single cycle.

// File: rtl/resync_pkg.sv
package resync_pkg;
  localparam int NTILE   = 4;
  localparam int MAJ_MIN = 3;
  localparam int HIT_W   = $clog2(NTILE + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_CMP   = 2'd2,
    ST_WRITE = 2'd3
  } rs_state_t;
endpackage

// File: rtl/resync_vote.sv
module resync_vote
  import resync_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [NTILE*DATA_W-1:0] words_i,
  output logic [DATA_W-1:0]       winner_o,
  output logic                    found_o,
  output logic [NTILE-1:0]        differ_o
);
  logic [DATA_W-1:0] lane [NTILE];
  logic [HIT_W-1:0]  hits [NTILE];
  logic [NTILE-1:0]  agree;

  genvar g;
  generate
    for (g = 0; g < NTILE; g++) begin : g_lane
      assign lane[g] = words_i[g*DATA_W +: DATA_W];
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NTILE; i++) begin
      hits[i] = '0;
      for (int j = 0; j < NTILE; j++) begin
        hits[i] = hits[i] + HIT_W'(lane[i] == lane[j]);
      end
      agree[i] = (hits[i] >= HIT_W'(MAJ_MIN));
    end
  end

  always_comb begin
    winner_o = '0;
    for (int i = NTILE - 1; i >= 0; i--) begin
      if (agree[i]) winner_o = lane[i];
    end
    found_o = |agree;
    for (int j = 0; j < NTILE; j++) begin
      differ_o[j] = found_o && (lane[j] != winner_o);
    end
  end
endmodule

// File: rtl/resync_seq.sv
module resync_seq
  import resync_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int MAX_PASSES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              found_i,
  input  logic [NTILE-1:0]  differ_i,
  input  logic [DATA_W-1:0] winner_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [NTILE-1:0]  we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              done_o,
  output logic              unrecov_o,
  output logic              clr_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PASS_W = $clog2(MAX_PASSES + 1);

  rs_state_t         state_q;
  logic [PASS_W-1:0] pass_q;
  logic              dirty_q;
  logic              at_last;
  logic              step;

  assign at_last = (addr_o == ADDR_W'(DEPTH - 1));
  assign step    = (state_q == ST_WRITE) ||
                   ((state_q == ST_CMP) && found_i && !(|differ_i));
  assign clr_o   = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pass_q    <= '0;
      dirty_q   <= 1'b0;
      addr_o    <= '0;
      we_o      <= '0;
      wdata_o   <= '0;
      done_o    <= 1'b0;
      unrecov_o <= 1'b0;
    end else begin
      we_o <= '0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            done_o    <= 1'b0;
            unrecov_o <= 1'b0;
            addr_o    <= '0;
            pass_q    <= PASS_W'(1);
            dirty_q   <= 1'b0;
            state_q   <= ST_READ;
          end
        end
        ST_READ: state_q <= ST_CMP;
        ST_CMP: begin
          if (!found_i) begin
            unrecov_o <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (|differ_i) begin
            we_o    <= differ_i;
            wdata_o <= winner_i;
            dirty_q <= 1'b1;
            state_q <= ST_WRITE;
          end
        end
        default: ;
      endcase

      if (step) begin
        if (!at_last) begin
          addr_o  <= addr_o + 1'b1;
          state_q <= ST_READ;
        end else if (!dirty_q && (state_q == ST_CMP)) begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end else if (pass_q == PASS_W'(MAX_PASSES)) begin
          unrecov_o <= 1'b1;
          state_q   <= ST_IDLE;
        end else begin
          pass_q  <= pass_q + 1'b1;
          dirty_q <= 1'b0;
          addr_o  <= '0;
          state_q <= ST_READ;
        end
      end
    end
  end
endmodule

// File: rtl/resync_tally.sv
module resync_tally
  import resync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr_i,
  input  logic [NTILE-1:0]       inc_i,
  output logic [NTILE*CNT_W-1:0] cnt_o
);
  genvar g;
  generate
    for (g = 0; g < NTILE; g++) begin : g_cnt
      logic [CNT_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (rst || clr_i) begin
          val_q <= '0;
        end else if (inc_i[g] && (val_q != {CNT_W{1'b1}})) begin
          val_q <= val_q + 1'b1;
        end
      end
      assign cnt_o[g*CNT_W +: CNT_W] = val_q;
    end
  endgenerate
endmodule

// File: rtl/mem_resync_engine.sv
module mem_resync_engine
  import resync_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int MAX_PASSES = 4,
  parameter int CNT_W      = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output logic                    done,
  output logic                    unrecov,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [NTILE-1:0]        mem_we,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [NTILE*DATA_W-1:0] mem_rdata,
  output logic [NTILE*CNT_W-1:0]  corr_count
);
  logic [DATA_W-1:0] winner;
  logic              found;
  logic [NTILE-1:0]  differ;
  logic              clr_cnt;

  resync_vote #(.DATA_W(DATA_W)) u_vote (
    .words_i  (mem_rdata),
    .winner_o (winner),
    .found_o  (found),
    .differ_o (differ)
  );

  resync_seq #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .MAX_PASSES (MAX_PASSES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .found_i   (found),
    .differ_i  (differ),
    .winner_i  (winner),
    .addr_o    (mem_addr),
    .we_o      (mem_we),
    .wdata_o   (mem_wdata),
    .done_o    (done),
    .unrecov_o (unrecov),
    .clr_o     (clr_cnt)
  );

  resync_tally #(.CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst   (rst),
    .clr_i (clr_cnt),
    .inc_i (mem_we),
    .cnt_o (corr_count)
  );
endmodule

// File: rtl/mem_resync_engine_chk.sv
module mem_resync_engine_chk
  import resync_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start,
  input logic                   done,
  input logic                   unrecov,
  input logic [NTILE-1:0]       mem_we,
  input logic [NTILE*CNT_W-1:0] corr_count
);
  // R9: result flags are exclusive
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && unrecov));

  // R3: a three-way majority leaves at most one tile to repair
  assert_single_repair_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(mem_we) <= 1);

  // R4: a repair is one write cycle, followed by a read
  assert_write_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (|mem_we) |=> !(|mem_we));

  // R5: nothing is written once the walk has aborted
  assert_no_write_when_failed_R5: assert property (@(posedge clk) disable iff (rst)
    unrecov |-> (mem_we == '0));

  // R9: flags hold until a start arrives
  assert_done_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  assert_unrecov_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (unrecov && !start) |=> unrecov);
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
    ((done || unrecov) && start) |=> !(done || unrecov));

  genvar g;
  generate
    for (g = 0; g < NTILE; g++) begin : g_cnt_chk
      // R7: a counter moves only on a write to its tile or an accepted start
      assert_count_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!start && !mem_we[g]) |=> $stable(corr_count[g*CNT_W +: CNT_W]));
    end
  endgenerate
endmodule

bind mem_resync_engine mem_resync_engine_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .done       (done),
  .unrecov    (unrecov),
  .mem_we     (mem_we),
  .corr_count (corr_count)
);

// File: tb/mem_resync_engine_test.sv
module mem_resync_engine_test;
  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int MAXP  = 4;
  localparam int CW    = 8;
  localparam int NT    = 4;

  typedef struct {
    bit done;
    bit unrec;
    int lat;
    int cnt [NT];
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic            done, unrecov;
  logic [AW-1:0]   mem_addr;
  logic [NT-1:0]   mem_we;
  logic [DW-1:0]   mem_wdata;
  logic [NT*DW-1:0] mem_rdata;
  logic [NT*CW-1:0] corr_count;

  logic [DW-1:0] ram     [NT][DEPTH];
  logic [DW-1:0] img     [NT][DEPTH];
  logic [DW-1:0] exp_img [NT][DEPTH];
  bit            stuck_en = 0;
  int            stuck_t = 0, stuck_a = 0;

  exp_t sb [$];
  int   checks = 0, failures = 0;
  bit   armed = 0, finished = 0;
  int   elapsed = 0;

  always #10 clk = ~clk;

  mem_resync_engine #(.DATA_W(DW), .ADDR_W(AW), .MAX_PASSES(MAXP), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .done(done), .unrecov(unrecov),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .corr_count(corr_count)
  );

  // four tile memories, one-cycle read latency, optional stuck word
  always @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      mem_rdata[t*DW +: DW] <= ram[t][mem_addr];
      if (mem_we[t] && !(stuck_en && t == stuck_t && int'(mem_addr) == stuck_a))
        ram[t][mem_addr] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic fill(input int seed);
    for (int a = 0; a < DEPTH; a++) begin
      for (int t = 0; t < NT; t++) img[t][a] = DW'(a * 16'h1357 ^ seed);
    end
  endtask

  // behavioural expectation derived from the requirements
  task automatic model_run(output exp_t e);
    logic [DW-1:0] m [NT][DEPTH];
    bit stop;
    m = img;
    e.done = 0; e.unrec = 0; e.lat = 0;
    for (int t = 0; t < NT; t++) e.cnt[t] = 0;
    stop = 0;
    for (int p = 1; p <= MAXP && !stop; p++) begin
      bit dirty;
      dirty = 0;
      for (int a = 0; a < DEPTH && !stop; a++) begin
        bit found;
        logic [DW-1:0] mv;
        bit any;
        found = 0; mv = '0; any = 0;
        for (int i = 0; i < NT; i++) begin
          int c;
          c = 0;
          for (int j = 0; j < NT; j++) if (m[j][a] == m[i][a]) c++;
          if (c >= 3) begin found = 1; mv = m[i][a]; end
        end
        if (!found) begin
          e.lat += 2; e.unrec = 1; stop = 1;
        end else begin
          for (int t = 0; t < NT; t++) begin
            if (m[t][a] != mv) begin
              any = 1;
              e.cnt[t]++;
              if (!(stuck_en && t == stuck_t && a == stuck_a)) m[t][a] = mv;
            end
          end
          if (any) dirty = 1;
          e.lat += any ? 3 : 2;
        end
      end
      if (!stop && !dirty) begin e.done = 1; stop = 1; end
    end
    if (!stop) e.unrec = 1;
    exp_img = m;
  endtask

  // driver: load memories, push expectation, pulse start
  task automatic run_scn(input int mid_pulse);
    exp_t e;
    for (int t = 0; t < NT; t++)
      for (int a = 0; a < DEPTH; a++) ram[t][a] <= img[t][a];
    model_run(e);
    sb.push_back(e);
    @(posedge clk); #2;
    start = 1'b1; armed = 1; elapsed = 0;
    @(posedge clk); #2;
    start = 1'b0;
    if (mid_pulse > 0) begin
      repeat (mid_pulse) @(posedge clk);
      #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
    end
    wait (finished);
    finished = 0;
    repeat (5) @(posedge clk);
    #12;
    chk(done == e.done, "R9", "done held while idle", done, e.done);
    chk(unrecov == e.unrec, "R9", "unrecov held while idle", unrecov, e.unrec);
  endtask

  // monitor: pop expectation and compare when the engine reports
  always @(negedge clk) begin
    if (armed) begin
      elapsed++;
      if (elapsed == 2) begin
        chk(!done && !unrecov, "R9", "flags cleared after start",
            {done, unrecov}, 0);
      end
      if (elapsed >= 2 && (done || unrecov)) begin
        exp_t e;
        bit img_ok;
        e = sb.pop_front();
        chk(done == e.done, "R2", "done result", done, e.done);
        chk(unrecov == e.unrec, "R5", "unrecov result", unrecov, e.unrec);
        chk(elapsed - 2 == e.lat, "R4", "cycles to finish", elapsed - 2, e.lat);
        for (int t = 0; t < NT; t++)
          chk(int'(corr_count[t*CW +: CW]) == e.cnt[t], "R7", "tile correction count",
              corr_count[t*CW +: CW], e.cnt[t]);
        img_ok = 1;
        for (int t = 0; t < NT; t++)
          for (int a = 0; a < DEPTH; a++)
            if (ram[t][a] !== exp_img[t][a]) img_ok = 0;
        chk(img_ok, "R3", "memory contents after walk", img_ok, 1);
        armed = 0;
        finished = 1;
      end
    end
  end

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(!done && !unrecov, "R1", "flags after reset", {done, unrecov}, 0);
    chk(mem_we == '0, "R1", "write enables after reset", mem_we, 0);
    chk(corr_count == '0, "R1", "counters after reset", corr_count, 0);

    // R2: already consistent, one clean pass
    fill(16'h00A5);
    run_scn(0);
    chk(1, "R2", "clean walk issued", 1, 1);

    // R3 R4: one tile wrong at three addresses, incl. first and last
    fill(16'h3C00);
    img[1][0] = 16'hDEAD; img[1][7] = 16'hBEEF; img[1][DEPTH-1] = 16'h0001;
    run_scn(0);

    // R3 R7: each tile wrong somewhere
    fill(16'h0F0F);
    img[0][2] = 16'h1111; img[1][5] = 16'h2222; img[2][9] = 16'h3333;
    img[3][9 + 1] = 16'h4444; img[3][12] = 16'h5555;
    run_scn(0);

    // R5: 2-2 split at address 6 after a repair at 1
    fill(16'h7777);
    img[2][1] = 16'h0000;
    img[0][6] = 16'hAAAA; img[1][6] = 16'hAAAA;
    run_scn(0);

    // R5: four different words at address 3
    fill(16'h1234);
    img[0][3] = 16'h0001; img[1][3] = 16'h0002; img[2][3] = 16'h0003;
    run_scn(0);

    // R7: counters cleared by a later start, clean walk
    fill(16'h5A5A);
    run_scn(0);

    // R6: a word in tile 3 never takes the write
    fill(16'h6C6C);
    img[3][4] = 16'hFFFF;
    stuck_en = 1; stuck_t = 3; stuck_a = 4;
    run_scn(0);
    stuck_en = 0;
    chk(1, "R6", "pass limit scenario issued", 1, 1);

    // R8: start pulsed mid-walk is ignored (latency and counts unchanged)
    fill(16'h2468);
    img[2][8] = 16'h9999;
    run_scn(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule